// File: doc/BRIEF.md
# Power-Good Window Monitor with Hysteresis

This block decides whether a regulated supply may be reported as healthy. It receives a digitized feedback code and a reference code. On each sample strobe it compares the feedback code against four thresholds that it derives from the reference with fixed-point scaling. Two hysteretic trip pairs, one above the reference and one below it, keep a high-side flag and a low-side flag. Feedback that dwells near a trip point therefore cannot make the flags chatter.

The power-good output is a logic level. A 1 stands in for an open-drain pad that is released, and a 0 for a pad that is pulled low. Power-good is the last step of start-up: it rises only after the soft-start sequence has reported completion while the block is enabled. It drops at once, with no clock edge in between, when enable falls, when the fault-shutdown input is raised or when either window flag is set. After a disable or a fault shutdown, a new soft-start completion is needed before power-good can rise again.

Top module: `pg_window_mon`

## Requirements
- R1: On a clock edge with `sample_stb` high, `ov_flag` becomes 1 when `fb_code` is strictly greater than floor(`ref_code` x 1110 / 1000).
- R2: On a strobed edge, a set `ov_flag` clears only when `fb_code` <= floor(`ref_code` x 1075 / 1000). For feedback between the two high-side thresholds the flag keeps its previous value.
- R3: On a strobed edge, `uv_flag` becomes 1 when `fb_code` is strictly less than floor(`ref_code` x 890 / 1000).
- R4: On a strobed edge, a set `uv_flag` clears only when `fb_code` >= floor(`ref_code` x 925 / 1000). Between the two low-side thresholds the flag holds.
- R5: `pgood` is 0 whenever `ov_flag` or `uv_flag` is 1, and returns to 1 once both are 0 (other conditions permitting).
- R6: `pgood` can be 1 only after `ss_done` has been 1 on a clock edge while `enable` was 1. This soft-start completion is remembered, so `ss_done` may later fall without effect.
- R7: `enable` at 0 forces `pgood` to 0 combinationally, in the same cycle. It also erases the remembered soft-start completion, so a fresh `ss_done` is required after re-enabling.
- R8: `fault_shdn` at 1 forces `pgood` to 0 combinationally and erases the remembered soft-start completion.
- R9: While `rst_n` is 0, both flags and `pgood` are 0. The flags change only on a clock edge with `sample_stb` high, and show the new value one clock after that strobe is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_stb | input | 1 | Compare the current codes on this edge |
| fb_code | input | 12 | Digitized feedback voltage, unsigned |
| ref_code | input | 12 | Digitized reference voltage, unsigned |
| enable | input | 1 | Regulator enable level |
| ss_done | input | 1 | Soft-start completed |
| fault_shdn | input | 1 | Protection logic has shut the regulator down |
| pgood | output | 1 | 1 = supply good (pad released), 0 = pulled low |
| ov_flag | output | 1 | Feedback above the high-side window |
| uv_flag | output | 1 | Feedback below the low-side window |

## Verification
The hardest cases to reach from the ports are those in which a flag must hold its value while the feedback sits between a set threshold and its clear threshold. The boundaries also have to be hit exactly despite rounding toward zero. The bench uses a reference code of 1001, for which the scaled thresholds are 1111, 1076, 890 and 925. It walks the feedback one code at a time across each boundary and across the hysteresis band, so an off-by-one compare or a wrong rounding shows up as a flag that trips one code early or late. Separate scenarios drop `enable` and raise `fault_shdn` between clock edges. They check `pgood` before the next edge, then confirm that re-enabling alone does not restore it.

// File: rtl/pg_mon_pkg.sv
`timescale 1ns/1ps
package pg_mon_pkg;

    // Fixed-point scaling: threshold = ref * NUM / SCALE_DEN
    localparam int unsigned SCALE_DEN   = 1000;
    localparam int unsigned NUM_OV_SET  = 1110;
    localparam int unsigned NUM_OV_CLR  = 1075;
    localparam int unsigned NUM_UV_SET  = 890;
    localparam int unsigned NUM_UV_CLR  = 925;
    localparam int unsigned THR_COUNT   = 4;

    // Threshold slot order used by the generate loop in the top module
    localparam int unsigned IDX_OV_SET  = 0;
    localparam int unsigned IDX_OV_CLR  = 1;
    localparam int unsigned IDX_UV_SET  = 2;
    localparam int unsigned IDX_UV_CLR  = 3;

    localparam int unsigned THR_NUM [THR_COUNT] = '{NUM_OV_SET, NUM_OV_CLR,
                                                   NUM_UV_SET, NUM_UV_CLR};

    // Window side selector for the hysteretic comparator
    typedef enum logic {
        SIDE_BELOW = 1'b0,
        SIDE_ABOVE = 1'b1
    } win_side_e;

    // Registered state of the power-good gate
    typedef struct packed {
        logic ss_seen;
    } gate_state_t;

    // Registered state of one hysteretic comparator
    typedef struct packed {
        logic trip;
    } cmp_state_t;

endpackage

// File: rtl/pg_scale.sv
`timescale 1ns/1ps
// Scales an unsigned code by NUM/DEN, rounding toward zero.
module pg_scale #(
    parameter int unsigned W   = 12,
    parameter int unsigned NUM = 1000,
    parameter int unsigned DEN = 1000
) (
    input  logic [W-1:0] code_i,
    output logic [W:0]   scaled_o
);
    localparam int unsigned NUM_W = $clog2(NUM + 1);
    localparam int unsigned PW    = W + NUM_W;

    logic [PW-1:0] product;
    logic [PW-1:0] quotient;

    always_comb begin
        product  = PW'(code_i) * PW'(NUM);
        quotient = product / PW'(DEN);
        scaled_o = (W+1)'(quotient);
    end
endmodule

// File: rtl/pg_hyst_cmp.sv
`timescale 1ns/1ps
// Hysteretic comparator, updated only on a strobed edge.
module pg_hyst_cmp
    import pg_mon_pkg::*;
#(
    parameter int unsigned W    = 12,
    parameter win_side_e   SIDE = SIDE_ABOVE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb_i,
    input  logic [W-1:0] sample_i,
    input  logic [W:0]   set_lvl_i,
    input  logic [W:0]   clr_lvl_i,
    output logic         trip_o
);
    cmp_state_t st_d, st_q;
    logic       hit_set;
    logic       hit_clr;
    logic [W:0] sample_x;

    assign sample_x = {1'b0, sample_i};

    generate
        if (SIDE == SIDE_ABOVE) begin : g_above
            assign hit_set = (sample_x > set_lvl_i);
            assign hit_clr = (sample_x <= clr_lvl_i);
        end else begin : g_below
            assign hit_set = (sample_x < set_lvl_i);
            assign hit_clr = (sample_x >= clr_lvl_i);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (stb_i) begin
            if (hit_set) begin
                st_d.trip = 1'b1;
            end else if (hit_clr) begin
                st_d.trip = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trip_o = st_q.trip;
endmodule

// File: rtl/pg_gate.sv
`timescale 1ns/1ps
// Soft-start memory and combinational power-good gating.
module pg_gate
    import pg_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic ss_done_i,
    input  logic fault_i,
    input  logic ov_i,
    input  logic uv_i,
    output logic pgood_o
);
    gate_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable_i || fault_i) begin
            st_d.ss_seen = 1'b0;
        end else if (ss_done_i) begin
            st_d.ss_seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pgood_o = st_q.ss_seen & enable_i & ~fault_i & ~ov_i & ~uv_i;
endmodule

// File: rtl/pg_window_mon.sv
`timescale 1ns/1ps
module pg_window_mon
    import pg_mon_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample_stb,
    input  logic [W-1:0] fb_code,
    input  logic [W-1:0] ref_code,
    input  logic         enable,
    input  logic         ss_done,
    input  logic         fault_shdn,
    output logic         pgood,
    output logic         ov_flag,
    output logic         uv_flag
);
    logic [W:0] thr [THR_COUNT];

    generate
        for (genvar i = 0; i < THR_COUNT; i++) begin : g_thr
            pg_scale #(
                .W   (W),
                .NUM (THR_NUM[i]),
                .DEN (SCALE_DEN)
            ) u_scale (
                .code_i   (ref_code),
                .scaled_o (thr[i])
            );
        end
    endgenerate

    pg_hyst_cmp #(.W(W), .SIDE(SIDE_ABOVE)) u_ov_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_i     (sample_stb),
        .sample_i  (fb_code),
        .set_lvl_i (thr[IDX_OV_SET]),
        .clr_lvl_i (thr[IDX_OV_CLR]),
        .trip_o    (ov_flag)
    );

    pg_hyst_cmp #(.W(W), .SIDE(SIDE_BELOW)) u_uv_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_i     (sample_stb),
        .sample_i  (fb_code),
        .set_lvl_i (thr[IDX_UV_SET]),
        .clr_lvl_i (thr[IDX_UV_CLR]),
        .trip_o    (uv_flag)
    );

    pg_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable),
        .ss_done_i (ss_done),
        .fault_i   (fault_shdn),
        .ov_i      (ov_flag),
        .uv_i      (uv_flag),
        .pgood_o   (pgood)
    );
endmodule

// File: rtl/pg_window_mon_chk.sv
`timescale 1ns/1ps
module pg_window_mon_chk #(
    parameter int unsigned W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sample_stb,
    input logic [W-1:0] fb_code,
    input logic         enable,
    input logic         fault_shdn,
    input logic         pgood,
    input logic         ov_flag,
    input logic         uv_flag,
    input logic [W:0]   thr_ov_set,
    input logic [W:0]   thr_ov_clr,
    input logic [W:0]   thr_uv_set,
    input logic [W:0]   thr_uv_clr
);
    p_ov_rise_above_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ov_flag) |-> $past({1'b0, fb_code} > thr_ov_set));

    p_ov_fall_low_enough_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ov_flag) |-> $past({1'b0, fb_code} <= thr_ov_clr));

    p_uv_rise_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uv_flag) |-> $past({1'b0, fb_code} < thr_uv_set));

    p_uv_fall_high_enough_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uv_flag) |-> $past({1'b0, fb_code} >= thr_uv_clr));

    p_pg_low_on_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_flag || uv_flag) |-> !pgood);

    p_pg_low_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !pgood);

    p_pg_low_on_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_shdn |-> !pgood);

    p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> ($stable(ov_flag) && $stable(uv_flag)));
endmodule

bind pg_window_mon pg_window_mon_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .fb_code    (fb_code),
    .enable     (enable),
    .fault_shdn (fault_shdn),
    .pgood      (pgood),
    .ov_flag    (ov_flag),
    .uv_flag    (uv_flag),
    .thr_ov_set (thr[0]),
    .thr_ov_clr (thr[1]),
    .thr_uv_set (thr[2]),
    .thr_uv_clr (thr[3])
);

// File: tb/pg_window_mon_test.sv
`timescale 1ns/1ps
module pg_window_mon_test;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sample_stb = 1'b0;
    logic [W-1:0] fb_code = '0;
    logic [W-1:0] ref_code = '0;
    logic         enable = 1'b0;
    logic         ss_done = 1'b0;
    logic         fault_shdn = 1'b0;
    logic         pgood, ov_flag, uv_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pg_window_mon #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
        .fb_code(fb_code), .ref_code(ref_code), .enable(enable),
        .ss_done(ss_done), .fault_shdn(fault_shdn),
        .pgood(pgood), .ov_flag(ov_flag), .uv_flag(uv_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Present one sample on a strobe; results visible at the following negedge
    task automatic do_sample(input int fb, input int rf);
        @(negedge clk);
        fb_code    = W'(fb);
        ref_code   = W'(rf);
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    task automatic soft_start();
        @(negedge clk);
        ss_done = 1'b1;
        @(negedge clk);
        ss_done = 1'b0;
    endtask

    task automatic t_reset();
        enable  = 1'b1;
        ss_done = 1'b1;
        fb_code = 12'd4000; ref_code = 12'd1000; sample_stb = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 reset pgood", pgood, 0);
        chk("R9 reset ov", ov_flag, 0);
        chk("R9 reset uv", uv_flag, 0);
        sample_stb = 1'b0; ss_done = 1'b0; enable = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_startup();
        enable = 1'b1;
        do_sample(2000, 2000);
        chk("R6 no pgood before soft-start", pgood, 0);
        soft_start();
        chk("R6 pgood after soft-start", pgood, 1);
        repeat (3) @(negedge clk);
        chk("R6 pgood held after ss_done falls", pgood, 1);
    endtask

    task automatic t_ov_main();
        do_sample(2221, 2000);
        chk("R1 ov set above 2220", ov_flag, 1);
        chk("R5 pgood low on ov", pgood, 0);
        do_sample(2151, 2000);
        chk("R2 ov holds in band", ov_flag, 1);
        do_sample(2150, 2000);
        chk("R2 ov clears at 2150", ov_flag, 0);
        chk("R5 pgood back", pgood, 1);
    endtask

    task automatic t_uv_main();
        do_sample(1779, 2000);
        chk("R3 uv set below 1780", uv_flag, 1);
        chk("R5 pgood low on uv", pgood, 0);
        do_sample(1849, 2000);
        chk("R4 uv holds in band", uv_flag, 1);
        do_sample(1850, 2000);
        chk("R4 uv clears at 1850", uv_flag, 0);
        chk("R5 pgood back after uv", pgood, 1);
    endtask

    // ref 1001 -> thresholds 1111, 1076, 890, 925 after truncation
    task automatic t_rounding();
        do_sample(1111, 1001);
        chk("R1 no ov at threshold", ov_flag, 0);
        do_sample(1112, 1001);
        chk("R1 ov one above", ov_flag, 1);
        do_sample(1077, 1001);
        chk("R2 ov holds at 1077", ov_flag, 1);
        do_sample(1076, 1001);
        chk("R2 ov clears at 1076", ov_flag, 0);
        do_sample(890, 1001);
        chk("R3 no uv at threshold", uv_flag, 0);
        do_sample(889, 1001);
        chk("R3 uv one below", uv_flag, 1);
        do_sample(924, 1001);
        chk("R4 uv holds at 924", uv_flag, 1);
        do_sample(925, 1001);
        chk("R4 uv clears at 925", uv_flag, 0);
        do_sample(1001, 1001);
        chk("R5 both clear pgood", pgood, 1);
    endtask

    task automatic t_no_strobe();
        @(negedge clk);
        fb_code = 12'd3000; ref_code = 12'd1001;
        repeat (4) @(negedge clk);
        chk("R9 ov ignores unstrobed high", ov_flag, 0);
        chk("R9 pgood unaffected", pgood, 1);
        fb_code = 12'd100;
        repeat (2) @(negedge clk);
        chk("R9 uv ignores unstrobed low", uv_flag, 0);
        // strobe presented; flag visible only after the edge
        fb_code = 12'd3000; sample_stb = 1'b1;
        #2;
        chk("R9 no change before edge", ov_flag, 0);
        @(negedge clk);
        sample_stb = 1'b0;
        chk("R9 ov after strobed edge", ov_flag, 1);
        do_sample(1001, 1001);
        chk("R9 recovered", pgood, 1);
    endtask

    task automatic t_enable_drop();
        @(negedge clk);
        #3 enable = 1'b0;
        #2;
        chk("R7 pgood low same cycle", pgood, 0);
        repeat (2) @(negedge clk);
        enable = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 re-enable needs soft-start", pgood, 0);
        soft_start();
        chk("R7 pgood after new soft-start", pgood, 1);
    endtask

    task automatic t_fault();
        @(negedge clk);
        #3 fault_shdn = 1'b1;
        #2;
        chk("R8 pgood low on fault", pgood, 0);
        repeat (2) @(negedge clk);
        fault_shdn = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 fault cleared soft-start memory", pgood, 0);
        // ss_done together with fault must not latch
        fault_shdn = 1'b1; ss_done = 1'b1;
        @(negedge clk);
        fault_shdn = 1'b0; ss_done = 1'b0;
        @(negedge clk);
        chk("R8 ss_done during fault ignored", pgood, 0);
        soft_start();
        chk("R8 pgood after fault and soft-start", pgood, 1);
    endtask

    initial begin
        t_reset();
        t_startup();
        t_ov_main();
        t_uv_main();
        t_rounding();
        t_no_strobe();
        t_enable_drop();
        t_fault();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule